// File: doc/BRIEF.md
# Segmented Self-Triggered Acquisition Manager

This block keeps track of a sampling memory that is cut into many short segments. A continuous sample stream is written into the current segment, one position per valid sample. The trigger comes from the samples themselves: any sample strictly above a programmable level marks the segment being written. When a segment's last position has been written, a marked segment is kept and described to the consumer. An unmarked segment is abandoned, and its contents will be overwritten later. In both cases the writer moves on to the next free segment.

Each kept segment is stamped with a coarse time from a free-running counter. The stamp is the counter value on the first triggering sample in that segment. Descriptors, each made of a segment index and a timestamp, leave the block on a valid/ready stream. The oldest descriptor comes first. The consumer is told that data exists; it never polls.

Once a descriptor is accepted, the block steps a read address through that segment, one position per read strobe from the consumer. It frees the segment after the final position has been read. Writing and readout run at the same time. A trigger that would leave the writer with no free segment is dropped and counted.

Top module: `acq_seg_manager`

## Requirements
- R1: After a synchronous active-high reset, the write address is segment 0 offset 0, `desc_valid` and `rd_active` are low, `ovf_count` is zero, every segment is free and the timestamp counter is zero.
- R2: `mem_waddr` is the write segment index (upper bits) joined with the offset (lower bits). `mem_we` follows `smp_valid`, and the offset advances by one for each valid sample, wrapping after `SEG_LEN-1`.
- R3: A valid sample whose value is strictly greater than `trig_level` triggers the current segment. A sample equal to or below the level does not.
- R4: At the end of a triggered segment, the segment is queued. Its timestamp is the counter value on the first triggering sample in that segment. The counter is zero at reset and adds one every clock.
- R5: A segment that ends without a trigger is not queued and produces no descriptor.
- R6: When a segment ends, the writer moves to the nearest free segment in ascending index order with wraparound. It never points at a segment that is queued or being read. A segment released on that same edge does not count as free.
- R7: When a triggered segment ends and no other segment is free, the trigger is dropped. The writer stays in the same segment, and `ovf_count` adds one, saturating at all ones.
- R8: Descriptors leave oldest first on `desc_valid`/`desc_ready`. A descriptor is transferred on a cycle where both are high. While `desc_ready` is low, `desc_valid`, `desc_seg` and `desc_ts` hold. `desc_valid` is low while a readout is in progress.
- R9: After a transfer, `rd_active` is high and `rd_addr` is the segment index joined with a read offset that starts at 0 and advances by one for each `rd_step`. On the clock edge that takes the `rd_step` for offset `SEG_LEN-1`, `rd_active` falls and the segment becomes free.
- R10: Writing and triggering go on unchanged while a segment is being read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One sample present this cycle |
| smp_data | input | DATA_W | Sample value |
| trig_level | input | DATA_W | Self-trigger level, compared strictly greater |
| mem_we | output | 1 | Sample memory write enable |
| mem_waddr | output | SEG_W+OFF_W | Sample memory write address |
| mem_wdata | output | DATA_W | Sample memory write data |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer accepts descriptor |
| desc_seg | output | SEG_W | Index of the captured segment |
| desc_ts | output | TS_W | Coarse timestamp of the captured segment |
| rd_active | output | 1 | Readout of a segment in progress |
| rd_step | input | 1 | Consumer reads the position at `rd_addr` |
| rd_addr | output | SEG_W+OFF_W | Sample memory read address |
| ovf_count | output | OVF_W | Dropped trigger count, saturating |

## Verification
The bench fills every segment. It then sends more triggers, which must be dropped without moving the writer; a design that committed anyway would hand out an index that is still queued, and one that failed to saturate would wrap `ovf_count` back to zero. It also triggers on the last sample of a segment and places several triggers in one segment. A wrong stamp capture would report the later trigger's time, or would miss the trigger on the final position. Segments filled with samples exactly at the level must be skipped, so an inclusive comparison would produce extra descriptors. Back-to-back segments written during readout, together with a held-off `desc_ready`, expose a free search that reuses a busy segment, a descriptor that changes under back-pressure, and a release that comes one cycle early or late.

// File: rtl/acq_pkg.sv
package acq_pkg;
  parameter int ACQ_NUM_SEG = 128;
  parameter int ACQ_SEG_LEN = 32;
  parameter int ACQ_DATA_W  = 12;
  parameter int ACQ_TS_W    = 16;
  parameter int ACQ_OVF_W   = 16;
endpackage

// File: rtl/acq_desc_fifo.sv
module acq_desc_fifo #(
  parameter int WIDTH = 23,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic             empty,
  output logic [WIDTH-1:0] dout
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    fill;
  logic             full, push_ok, pop_ok;

  assign empty   = (fill == '0);
  assign full    = (fill == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = store[rptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      fill <= fill + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/acq_free_search.sv
module acq_free_search #(
  parameter int NUM_SEG = 128
) (
  input  logic [NUM_SEG-1:0]         busy_map,
  input  logic [$clog2(NUM_SEG)-1:0] from_idx,
  output logic                       hit,
  output logic [$clog2(NUM_SEG)-1:0] idx
);
  localparam int SEG_W = $clog2(NUM_SEG);

  // Walk from the farthest candidate back to the nearest so the nearest wins.
  always_comb begin
    hit = 1'b0;
    idx = from_idx;
    for (int k = NUM_SEG - 1; k >= 1; k--) begin
      if (!busy_map[(int'(from_idx) + k) % NUM_SEG]) begin
        hit = 1'b1;
        idx = SEG_W'((int'(from_idx) + k) % NUM_SEG);
      end
    end
  end
endmodule

// File: rtl/acq_seg_manager.sv
module acq_seg_manager
  import acq_pkg::*;
#(
  parameter int NUM_SEG = ACQ_NUM_SEG,
  parameter int SEG_LEN = ACQ_SEG_LEN,
  parameter int DATA_W  = ACQ_DATA_W,
  parameter int TS_W    = ACQ_TS_W,
  parameter int OVF_W   = ACQ_OVF_W,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int OFF_W  = $clog2(SEG_LEN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_valid,
  input  logic [DATA_W-1:0]      smp_data,
  input  logic [DATA_W-1:0]      trig_level,
  output logic                   mem_we,
  output logic [SEG_W+OFF_W-1:0] mem_waddr,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic                   desc_valid,
  input  logic                   desc_ready,
  output logic [SEG_W-1:0]       desc_seg,
  output logic [TS_W-1:0]        desc_ts,
  output logic                   rd_active,
  input  logic                   rd_step,
  output logic [SEG_W+OFF_W-1:0] rd_addr,
  output logic [OVF_W-1:0]       ovf_count
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SEG_LEN - 1);

  logic [TS_W-1:0]    ts_cnt;
  logic [SEG_W-1:0]   wr_seg, nxt_seg, rd_seg;
  logic [OFF_W-1:0]   wr_off, rd_off;
  logic               trg_seen, nxt_hit, rd_busy;
  logic [TS_W-1:0]    trg_ts;
  logic [NUM_SEG-1:0] occ;

  logic hit, seg_end, seg_trig, commit, drop, take, rd_done, fifo_empty;
  logic [TS_W-1:0] stamp;
  logic [SEG_W+TS_W-1:0] fifo_head;

  // Write side
  assign hit      = smp_valid && (smp_data > trig_level);
  assign seg_end  = smp_valid && (wr_off == LAST_OFF);
  assign seg_trig = trg_seen || hit;
  assign stamp    = trg_seen ? trg_ts : ts_cnt;
  assign commit   = seg_end && seg_trig && nxt_hit;
  assign drop     = seg_end && seg_trig && !nxt_hit;

  assign mem_we    = smp_valid;
  assign mem_wdata = smp_data;
  assign mem_waddr = {wr_seg, wr_off};

  acq_free_search #(.NUM_SEG(NUM_SEG)) i_search (
    .busy_map (occ),
    .from_idx (wr_seg),
    .hit      (nxt_hit),
    .idx      (nxt_seg)
  );

  // Read side
  assign desc_valid = !fifo_empty && !rd_busy;
  assign take       = desc_valid && desc_ready;
  assign rd_done    = rd_busy && rd_step && (rd_off == LAST_OFF);
  assign rd_active  = rd_busy;
  assign rd_addr    = {rd_seg, rd_off};
  assign {desc_seg, desc_ts} = fifo_head;

  acq_desc_fifo #(.WIDTH(SEG_W + TS_W), .DEPTH(NUM_SEG)) i_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (commit),
    .din   ({wr_seg, stamp}),
    .pop   (take),
    .empty (fifo_empty),
    .dout  (fifo_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_cnt    <= '0;
      wr_seg    <= '0;
      wr_off    <= '0;
      trg_seen  <= 1'b0;
      trg_ts    <= '0;
      ovf_count <= '0;
    end else begin
      ts_cnt <= ts_cnt + 1'b1;
      if (smp_valid) begin
        wr_off <= (wr_off == LAST_OFF) ? '0 : wr_off + 1'b1;
        if (seg_end) begin
          trg_seen <= 1'b0;
          if (nxt_hit) wr_seg <= nxt_seg;
        end else if (hit && !trg_seen) begin
          trg_seen <= 1'b1;
          trg_ts   <= ts_cnt;
        end
      end
      if (drop && (ovf_count != '1)) ovf_count <= ovf_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ     <= '0;
      rd_busy <= 1'b0;
      rd_seg  <= '0;
      rd_off  <= '0;
    end else begin
      if (rd_done) occ[rd_seg] <= 1'b0;
      if (commit)  occ[wr_seg] <= 1'b1;
      if (take) begin
        rd_busy <= 1'b1;
        rd_seg  <= desc_seg;
        rd_off  <= '0;
      end else if (rd_busy && rd_step) begin
        rd_off <= (rd_off == LAST_OFF) ? '0 : rd_off + 1'b1;
        if (rd_off == LAST_OFF) rd_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acq_seg_manager_chk.sv
module acq_seg_manager_chk #(
  parameter int NUM_SEG = 128,
  parameter int SEG_LEN = 32,
  parameter int TS_W    = 16,
  parameter int OVF_W   = 16,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int OFF_W  = $clog2(SEG_LEN)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SEG-1:0] occ,
  input logic [SEG_W-1:0]   wr_seg,
  input logic [SEG_W-1:0]   rd_seg,
  input logic [OFF_W-1:0]   rd_off,
  input logic               rd_busy,
  input logic               rd_step,
  input logic               desc_valid,
  input logic               desc_ready,
  input logic [SEG_W-1:0]   desc_seg,
  input logic [TS_W-1:0]    desc_ts,
  input logic [OVF_W-1:0]   ovf_count
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SEG_LEN - 1);

  AST_WR_FREE: assert property (@(posedge clk) disable iff (rst)
    !occ[wr_seg]); // R6

  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (rst)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_seg) && $stable(desc_ts)); // R8

  AST_DESC_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_busy |-> !desc_valid); // R8

  AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
    rd_busy && rd_step && (rd_off != LAST_OFF) |=> rd_busy && (rd_off == OFF_W'($past(rd_off) + 1'b1))); // R9

  AST_RD_HELD: assert property (@(posedge clk) disable iff (rst)
    rd_busy |-> occ[rd_seg]); // R9

  AST_OVF_MONO: assert property (@(posedge clk) disable iff (rst)
    ovf_count >= $past(ovf_count)); // R7
endmodule

bind acq_seg_manager acq_seg_manager_chk #(
  .NUM_SEG(NUM_SEG), .SEG_LEN(SEG_LEN), .TS_W(TS_W), .OVF_W(OVF_W)
) i_chk (
  .clk(clk), .rst(rst), .occ(occ), .wr_seg(wr_seg), .rd_seg(rd_seg),
  .rd_off(rd_off), .rd_busy(rd_busy), .rd_step(rd_step),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_seg(desc_seg),
  .desc_ts(desc_ts), .ovf_count(ovf_count)
);

// File: tb/test_acq_seg_manager.sv
module test_acq_seg_manager;
  localparam int NS = 4, SL = 4, DW = 8, TSW = 16, OVW = 2;
  localparam int SW = 2, OFW = 2;
  localparam logic [DW-1:0] THR = 8'h40, HI = 8'h41;

  logic clk = 1'b0, rst = 1'b1;
  logic smp_valid = 1'b0, desc_ready = 1'b0, rd_step = 1'b0;
  logic [DW-1:0] smp_data = '0, trig_level = THR;
  logic mem_we, desc_valid, rd_active;
  logic [SW+OFW-1:0] mem_waddr, rd_addr;
  logic [DW-1:0] mem_wdata;
  logic [SW-1:0] desc_seg;
  logic [TSW-1:0] desc_ts;
  logic [OVW-1:0] ovf_count;

  int checks = 0, fails = 0;
  bit mon_en = 0, mon_hold = 1, mon_busy = 0;
  bit bocc [NS];
  int bwr = 0, bovf = 0;
  logic [TSW-1:0] bts;
  logic [SW+TSW-1:0] q [$];

  always #4 clk = ~clk;

  acq_seg_manager #(.NUM_SEG(NS), .SEG_LEN(SL), .DATA_W(DW), .TS_W(TSW), .OVF_W(OVW)) i_acq_seg_manager (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data), .trig_level(trig_level),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_seg(desc_seg), .desc_ts(desc_ts),
    .rd_active(rd_active), .rd_step(rd_step), .rd_addr(rd_addr), .ovf_count(ovf_count)
  );

  // Timestamp model: zero in reset, plus one per clock (R4)
  always @(posedge clk) begin
    if (rst) bts <= '0;
    else bts <= bts + 1'b1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  task automatic write_seg(input logic [SL-1:0] tmask);
    bit seen = 0, found;
    int nxt;
    logic [TSW-1:0] st = '0;
    for (int k = 0; k < SL; k++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = tmask[k] ? HI : THR;
      if (tmask[k] && !seen) begin seen = 1; st = bts; end
      #1;
      check(mem_we && mem_waddr == {SW'(bwr), OFW'(k)} && mem_wdata == smp_data, "R2 write address",
            mem_waddr, {SW'(bwr), OFW'(k)});
      if (k == SL - 1) begin
        found = 0; nxt = bwr;
        for (int j = NS - 1; j >= 1; j--)
          if (!bocc[(bwr + j) % NS]) begin found = 1; nxt = (bwr + j) % NS; end
        if (seen) begin
          if (found) begin q.push_back({SW'(bwr), st}); bocc[bwr] = 1; bwr = nxt; end
          else if (bovf < 3) bovf++;
        end else if (found) bwr = nxt;
      end
    end
  endtask

  // Monitor: consume descriptors and compare against the scoreboard
  initial begin
    logic [SW+TSW-1:0] exp;
    forever begin
      @(negedge clk);
      if (mon_en && desc_valid) begin
        mon_busy = 1;
        exp = (q.size() > 0) ? q.pop_front() : 'x;
        check({desc_seg, desc_ts} === exp, "R4 R8 descriptor order/stamp", {desc_seg, desc_ts}, exp);
        if (mon_hold) begin
          repeat (3) @(negedge clk);
          check(desc_valid && {desc_seg, desc_ts} === exp, "R8 hold under back-pressure",
                {desc_seg, desc_ts}, exp);
          mon_hold = 0;
        end
        desc_ready = 1'b1;
        @(negedge clk);
        desc_ready = 1'b0;
        check(rd_active && !desc_valid, "R9 readout started", rd_active, 1);
        for (int k = 0; k < SL; k++) begin
          check(rd_addr == {exp[SW+TSW-1:TSW], OFW'(k)}, "R9 read address", rd_addr,
                {exp[SW+TSW-1:TSW], OFW'(k)});
          rd_step = 1'b1;
          @(posedge clk);
          if (k == SL - 1) bocc[exp[SW+TSW-1:TSW]] = 0;
          @(negedge clk);
        end
        rd_step = 1'b0;
        check(!rd_active, "R9 readout ended after last step", rd_active, 0);
        mon_busy = 0;
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (q.size() == 0 && !mon_busy && !desc_valid && !rd_active) break;
    end
    check(q.size() == 0 && !rd_active, "R8 all descriptors served", q.size(), 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mem_waddr == '0, "R1 write address", mem_waddr, 0);
    check(!desc_valid && !rd_active, "R1 stream idle", {desc_valid, rd_active}, 0);
    check(ovf_count == '0, "R1 overflow count", ovf_count, 0);

    // Phase A: fill without readout
    write_seg(4'b0100);                 // seg 0, trigger mid-segment
    write_seg(4'b0000);                 // equal to level: skipped (R3, R5)
    idle(2);
    check(!desc_valid || q.size() == 1, "R5 no descriptor for skipped", q.size(), 1);
    check(mem_waddr == {SW'(2), OFW'(0)}, "R3 R6 writer advanced past skipped", mem_waddr, 8);
    write_seg(4'b1010);                 // seg 2, two triggers: first one stamps (R4)
    write_seg(4'b1000);                 // seg 3, trigger on last sample (R3)
    idle(1);
    check(mem_waddr == {SW'(1), OFW'(0)}, "R6 wrap to nearest free", mem_waddr, 4);
    for (int i = 0; i < 4; i++) write_seg(4'b0001);   // all others busy: drops (R7)
    write_seg(4'b0000);
    idle(2);
    check(ovf_count == OVW'(bovf), "R7 saturating drop count", ovf_count, bovf);
    check(mem_waddr == {SW'(1), OFW'(0)}, "R7 writer stays", mem_waddr, 4);

    // Readout of the backlog
    mon_en = 1;
    drain();

    // Phase B: write while reading (R10)
    write_seg(4'b0001); write_seg(4'b0010); write_seg(4'b0000); write_seg(4'b0100);
    write_seg(4'b1000); write_seg(4'b0011); write_seg(4'b0000); write_seg(4'b0001);
    idle(1);
    drain();
    check(ovf_count == OVW'(bovf), "R10 overflow count after concurrent run", ovf_count, bovf);
    check(mem_waddr == {SW'(bwr), OFW'(0)}, "R6 R10 final writer position", mem_waddr, bwr * SL);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule